// File: doc/BRIEF.md
# Link Reset Control Word Handler

This block carries the link-level hardware reset request in a framed serial link. It works in both directions. On receive, it watches the reset bit inside the dedicated hyperframe control word (index 130). It counts how many consecutive frames show that bit set. After four in a row, it raises a sticky request flag toward the application.

On transmit, it replaces the reset bit of the outgoing control byte with the application's request. It does this only in the insertion slot, and only when transmission of resets is enabled. Every other bit of that byte passes through unchanged.

Two configuration bits gate the two directions independently. A loss-of-frame indication restarts the persistence count but leaves an accepted request in place. The configuration reset may be asserted asynchronously. Its release is synchronized to the core clock inside the block.

Top module: `lrst_ctrl`

## Requirements
- R1: `rx_rst_req` rises one clock after the fourth consecutive qualifying receive frame whose control byte has bit 0 set. A qualifying frame is a cycle with `rx_pos_vld`=1 and `rx_cw_idx`=130. Three such frames do not raise it.
- R2: `rx_rst_req` can only become set at a qualifying frame for which `cfg_rx_rst_en`=1. With the enable at 0, no number of frames sets it.
- R3: Once set, `rx_rst_req` stays at 1 until the configuration reset. Later frames with bit 0 clear do not drop it.
- R4: A qualifying frame with bit 0 clear restarts the consecutive count at zero.
- R5: Cycles that are not qualifying frames neither advance nor clear the count. This covers `rx_pos_vld`=0, and also an index other than 130.
- R6: The count saturates at four. Take any run of set frames longer than four, seen while `cfg_rx_rst_en`=0. If the enable is then set, one more set frame raises the flag.
- R7: `rx_lof`=1 clears the consecutive count. Three set frames, a loss-of-frame cycle and one more set frame do not raise the flag.
- R8: `rx_lof`=1 does not clear an already-set `rx_rst_req`.
- R9: When `tx_slot`=1, bit 0 of `tx_cw_out` equals `app_rst_req` as sampled at the previous rising clock edge, ANDed with `cfg_tx_rst_en`. Otherwise that bit is 0.
- R10: Bits 7..1 of `tx_cw_out` always equal those of `tx_cw_in`. When `tx_slot`=0, the whole byte passes through.
- R11: `rst_n`=0 clears `rx_rst_req`, the count and the sampled transmit request at once. Release takes effect after two rising clock edges with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Configuration reset, active low, asynchronous assert |
| rx_pos_vld | input | 1 | Received control word position strobe |
| rx_cw_idx | input | 8 | Control word index within the hyperframe |
| rx_cw_byte | input | 8 | Received control byte at that index |
| rx_lof | input | 1 | Loss of frame indication |
| cfg_rx_rst_en | input | 1 | Enable for accepting received reset requests |
| cfg_tx_rst_en | input | 1 | Enable for sending reset requests |
| app_rst_req | input | 1 | Application request to send a link reset |
| tx_slot | input | 1 | Outgoing byte is the reset control word |
| tx_cw_in | input | 8 | Outgoing control byte before insertion |
| tx_cw_out | output | 8 | Outgoing control byte after insertion |
| rx_rst_req | output | 1 | Sticky received reset request |

## Verification
The bench builds the block with its default parameters: an 8-bit index and byte, index 130, and a persistence of four frames. With these values the count is three bits wide. A run of ten frames while receive is disabled would therefore wrap a counter that does not saturate, and the bench uses that to tell saturation apart from wrap-around. The short persistence also lets a single table walk exercise the ignored-cycle cases. Directed runs then cover loss of frame, the enables and insertion.

// File: rtl/lrst_pkg.sv
package lrst_pkg;
  // Bit of the reset control byte that carries the request
  localparam int unsigned RST_BIT = 0;

  // Per-cycle receive observation
  typedef struct packed {
    logic hit;   // qualifying frame position
    logic set;   // reset bit value at that position
  } lrst_obs_t;
endpackage

// File: rtl/lrst_rst_sync.sv
module lrst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lrst_rx_filter.sv
module lrst_rx_filter
  import lrst_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CW_W       = 8,
  parameter int unsigned RST_CW_IDX = 130,
  parameter int unsigned PERSIST    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_vld,
  input  logic [IDX_W-1:0] cw_idx,
  input  logic [CW_W-1:0]  cw_byte,
  input  logic             lof,
  input  logic             rx_en,
  output logic             req
);
  localparam int unsigned CNT_W = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PERSIST);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERSIST - 1);

  lrst_obs_t        obs;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             upd_en;

  assign obs.hit = pos_vld && (cw_idx == IDX_W'(RST_CW_IDX));
  assign obs.set = cw_byte[RST_BIT];
  assign upd_en  = lof | obs.hit;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (lof) begin
      cnt_d = '0;
    end else if (obs.hit) begin
      if (obs.set) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (rx_en && (cnt_q >= CNT_LAST)) flag_d = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign req = flag_q;
endmodule

// File: rtl/lrst_tx_insert.sv
module lrst_tx_insert
  import lrst_pkg::*;
#(
  parameter int unsigned CW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            app_req,
  input  logic            tx_en,
  input  logic            slot,
  input  logic [CW_W-1:0] cw_in,
  output logic [CW_W-1:0] cw_out
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= app_req;
  end

  always_comb begin
    cw_out = cw_in;
    if (slot) cw_out[RST_BIT] = req_q & tx_en;
  end
endmodule

// File: rtl/lrst_ctrl.sv
module lrst_ctrl #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CW_W       = 8,
  parameter int unsigned RST_CW_IDX = 130,
  parameter int unsigned PERSIST    = 4,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pos_vld,
  input  logic [IDX_W-1:0] rx_cw_idx,
  input  logic [CW_W-1:0]  rx_cw_byte,
  input  logic             rx_lof,
  input  logic             cfg_rx_rst_en,
  input  logic             cfg_tx_rst_en,
  input  logic             app_rst_req,
  input  logic             tx_slot,
  input  logic [CW_W-1:0]  tx_cw_in,
  output logic [CW_W-1:0]  tx_cw_out,
  output logic             rx_rst_req
);
  logic rst_n_s;

  lrst_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  lrst_rx_filter #(
    .IDX_W(IDX_W), .CW_W(CW_W), .RST_CW_IDX(RST_CW_IDX), .PERSIST(PERSIST)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pos_vld (rx_pos_vld),
    .cw_idx  (rx_cw_idx),
    .cw_byte (rx_cw_byte),
    .lof     (rx_lof),
    .rx_en   (cfg_rx_rst_en),
    .req     (rx_rst_req)
  );

  lrst_tx_insert #(.CW_W(CW_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .app_req (app_rst_req),
    .tx_en   (cfg_tx_rst_en),
    .slot    (tx_slot),
    .cw_in   (tx_cw_in),
    .cw_out  (tx_cw_out)
  );
endmodule

// File: rtl/lrst_ctrl_chk.sv
module lrst_ctrl_chk #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned CW_W       = 8,
  parameter int unsigned RST_CW_IDX = 130
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             rx_pos_vld,
  input logic [IDX_W-1:0] rx_cw_idx,
  input logic [CW_W-1:0]  rx_cw_byte,
  input logic             rx_lof,
  input logic             cfg_rx_rst_en,
  input logic             cfg_tx_rst_en,
  input logic             app_rst_req,
  input logic             tx_slot,
  input logic [CW_W-1:0]  tx_cw_in,
  input logic [CW_W-1:0]  tx_cw_out,
  input logic             rx_rst_req
);
  localparam logic [CW_W-1:0] KEEP = ~CW_W'(1);

  a_r1_rise_on_set_frame: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rx_rst_req) |-> $past(rx_pos_vld && (rx_cw_idx == IDX_W'(RST_CW_IDX))
                                && rx_cw_byte[0] && !rx_lof));

  a_r2_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rx_rst_req) |-> $past(cfg_rx_rst_en));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_rst_req |=> rx_rst_req);

  a_r7_lof_restarts: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rx_lof) |-> !$rose(rx_rst_req));

  a_r9_insert_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_slot && $past(rst_ok)) |-> (tx_cw_out[0] == ($past(app_rst_req) && cfg_tx_rst_en)));

  a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_ok)
    ((tx_cw_out ^ tx_cw_in) & KEEP) == '0);

  a_r10_no_slot_pass: assert property (@(posedge clk) disable iff (!rst_ok)
    !tx_slot |-> (tx_cw_out == tx_cw_in));
endmodule

bind lrst_ctrl lrst_ctrl_chk #(
  .IDX_W(IDX_W), .CW_W(CW_W), .RST_CW_IDX(RST_CW_IDX)
) u_chk (
  .clk           (clk),
  .rst_ok        (rst_n_s),
  .rx_pos_vld    (rx_pos_vld),
  .rx_cw_idx     (rx_cw_idx),
  .rx_cw_byte    (rx_cw_byte),
  .rx_lof        (rx_lof),
  .cfg_rx_rst_en (cfg_rx_rst_en),
  .cfg_tx_rst_en (cfg_tx_rst_en),
  .app_rst_req   (app_rst_req),
  .tx_slot       (tx_slot),
  .tx_cw_in      (tx_cw_in),
  .tx_cw_out     (tx_cw_out),
  .rx_rst_req    (rx_rst_req)
);

// File: tb/lrst_ctrl_tb.sv
`timescale 1ns/1ps
module lrst_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_pos_vld, rx_lof, cfg_rx_rst_en, cfg_tx_rst_en, app_rst_req, tx_slot;
  logic [7:0] rx_cw_idx, rx_cw_byte, tx_cw_in, tx_cw_out;
  logic       rx_rst_req;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lrst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_pos_vld(rx_pos_vld), .rx_cw_idx(rx_cw_idx),
    .rx_cw_byte(rx_cw_byte), .rx_lof(rx_lof), .cfg_rx_rst_en(cfg_rx_rst_en),
    .cfg_tx_rst_en(cfg_tx_rst_en), .app_rst_req(app_rst_req), .tx_slot(tx_slot),
    .tx_cw_in(tx_cw_in), .tx_cw_out(tx_cw_out), .rx_rst_req(rx_rst_req)
  );

  // {lof, vld, idx, byte, expected flag}
  localparam int NV = 7;
  localparam logic [18:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 8'd130, 8'h01, 1'b0},
    {1'b0, 1'b1, 8'd130, 8'h01, 1'b0},
    {1'b0, 1'b1, 8'd129, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'd130, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'd129, 8'h01, 1'b0},
    {1'b0, 1'b1, 8'd130, 8'h81, 1'b0},
    {1'b0, 1'b1, 8'd130, 8'hFF, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drive at negedge, capture at posedge, return at the next negedge
  task automatic frame(input logic lof, input logic vld, input logic [7:0] idx,
                       input logic [7:0] byt);
    rx_lof = lof; rx_pos_vld = vld; rx_cw_idx = idx; rx_cw_byte = byt;
    @(posedge clk);
    @(negedge clk);
    rx_lof = 1'b0; rx_pos_vld = 1'b0;
  endtask

  task automatic set_frames(input int n);
    for (int i = 0; i < n; i++) frame(1'b0, 1'b1, 8'd130, 8'h01);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; rx_pos_vld = 0; rx_lof = 0; rx_cw_idx = 0; rx_cw_byte = 0;
    cfg_rx_rst_en = 1; cfg_tx_rst_en = 1; app_rst_req = 0; tx_slot = 0; tx_cw_in = 0;
    do_reset();
    chk("R11 flag after reset", rx_rst_req, 0);
    tx_slot = 1; tx_cw_in = 8'h01; #1;
    chk("R11 tx bit after reset", tx_cw_out, 8'h00);
    tx_slot = 0;

    // table walk: R1 and R5 (ignored positions neither count nor clear)
    for (int v = 0; v < NV; v++) begin
      frame(VECS[v][18], VECS[v][17], VECS[v][16:9], VECS[v][8:1]);
      chk($sformatf("R1/R5 vector %0d", v), rx_rst_req, VECS[v][0]);
    end
    // R3: clear-bit frames do not drop the flag
    frame(1'b0, 1'b1, 8'd130, 8'h00);
    frame(1'b0, 1'b1, 8'd130, 8'h00);
    chk("R3 sticky", rx_rst_req, 1);
    // R8: loss of frame leaves flag set
    frame(1'b1, 1'b0, 8'd0, 8'h00);
    chk("R8 lof keeps flag", rx_rst_req, 1);
    // R11: asynchronous reset clears the flag immediately
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 async clear", rx_rst_req, 0);
    rst_n = 1'b1; repeat (3) @(negedge clk);

    // R1: three frames do not raise it
    set_frames(3);
    chk("R1 three frames", rx_rst_req, 0);
    // R4: clear bit restarts count
    frame(1'b0, 1'b1, 8'd130, 8'hFE);
    set_frames(3);
    chk("R4 restart after clear bit", rx_rst_req, 0);
    set_frames(1);
    chk("R4 fourth after restart", rx_rst_req, 1);

    // R7: lof restarts the count
    do_reset();
    set_frames(3);
    frame(1'b1, 1'b0, 8'd0, 8'h00);
    set_frames(1);
    chk("R7 lof restarts count", rx_rst_req, 0);
    set_frames(2);
    chk("R7 three after lof", rx_rst_req, 0);
    set_frames(1);
    chk("R7 four after lof", rx_rst_req, 1);

    // R2 and R6: disabled, ten frames, then enable and one more frame
    do_reset();
    cfg_rx_rst_en = 0;
    set_frames(10);
    chk("R2 disabled no flag", rx_rst_req, 0);
    cfg_rx_rst_en = 1;
    @(negedge clk);
    chk("R2 enable alone no flag", rx_rst_req, 0);
    set_frames(1);
    chk("R6 saturated count", rx_rst_req, 1);

    // transmit insertion
    do_reset();
    tx_slot = 1; tx_cw_in = 8'hA4; app_rst_req = 1; cfg_tx_rst_en = 1; #1;
    chk("R9 not yet sampled", tx_cw_out, 8'hA4);
    @(negedge clk);
    chk("R9 request inserted", tx_cw_out, 8'hA5);
    tx_slot = 0; #1;
    chk("R10 outside slot", tx_cw_out, 8'hA4);
    tx_slot = 1; cfg_tx_rst_en = 0; #1;
    chk("R9 tx disabled", tx_cw_out, 8'hA4);
    cfg_tx_rst_en = 1; app_rst_req = 0; tx_cw_in = 8'hFF;
    @(negedge clk);
    chk("R9/R10 bit cleared others kept", tx_cw_out, 8'hFE);
    tx_slot = 0; #1;
    chk("R10 passthrough full byte", tx_cw_out, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule